// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block generates the serial clock for an I2C master. It also gives the byte engine two timing strobes: one that marks when the next SDA bit may be driven, and one that marks the last cycle before SCL is let go. All timing comes from a packed configuration word. A shared prescaler turns the kernel clock into ticks, and per-phase tick counters then set the length of the low phase and the high phase. The low phase also has to cover a data hold delay followed by a data setup delay. SCL is an open-drain line. The output `sclOut` reads 1 when the line is released and 0 when it is pulled low.

The transfer controller drives three requests. It holds `enable` high while the generator may run, and it raises `runReq` to keep clocking. It raises `stallReq` to keep SCL low once the current low phase has ended, for example while it waits on a reload or on a software-ended transfer. The returned line level passes through a two-flop synchroniser. A slave that stretches the clock delays the high phase for as long as it holds SCL low.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, and after it until a run starts, `sclOut` is 1 and both strobes are 0.
- R2: Timing word layout: bits [27:24] prescaler P, [23:16] low count L, [15:8] high count H, [7:4] hold D, [3:0] setup S. One tick is P+1 kernel cycles. SCL is driven low for max(L+1, D+S+1) ticks.
- R3: After release, the high count starts only once the synchronised line reads high. With no stretching, SCL is released for 3 + (H+1)(P+1) cycles before it is pulled low again.
- R4: `sdaShiftStb` is a one-cycle pulse in each low phase. It comes D(P+1) cycles after SCL falls, which is the first low cycle when D is 0.
- R5: SCL is released no sooner than S+1 ticks after `sdaShiftStb`. `sclRiseStb` pulses in the last cycle that SCL is driven low.
- R6: While a slave holds SCL low after release, the high count waits. Each cycle of stretching adds one cycle to the released time.
- R7: If `stallReq` is high when the low phase ends, SCL stays low. `sclRiseStb` pulses in the first cycle `stallReq` is seen low, and SCL is released on the next cycle.
- R8: While `enable` is low, `sclOut` is 1 in the same cycle, both strobes are 0, and the phase and all counters return to idle.
- R9: The timing word is captured only while `enable` is low. Changes made while enabled have no effect until the block has been disabled and enabled again.
- R10: If `runReq` is low when a high phase ends, SCL stays released. From idle, a `runReq` seen at a clock edge pulls SCL low in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator enable; the timing word is captured while low |
| timingWord | input | 28 | Packed prescaler, low, high, hold and setup values |
| runReq | input | 1 | Keep generating clock periods |
| stallReq | input | 1 | Hold SCL low after the current low phase |
| sclIn | input | 1 | Sensed SCL line level |
| sclOut | output | 1 | SCL drive, 1 = released, 0 = pulled low |
| sdaShiftStb | output | 1 | SDA may now take its next bit |
| sclRiseStb | output | 1 | SCL is released after this cycle |

## Verification
The bench builds the block with its default parameters: a 4-bit prescaler, 8-bit low and high counts, 4-bit delays and two synchroniser stages. All corner cases are reached through the runtime timing word rather than through elaboration. The word values used cover prescaler settings of 0, 1 and 2, a zero hold delay, and a low phase whose length is set by hold plus setup rather than by the low count. A modelled slave stretches the clock by a fixed number of cycles, and the enable, run and stall requests are toggled in the middle of phases.

// File: rtl/scl_timing_pkg.sv
`timescale 1ns/1ps
package scl_timing_pkg;

  // Clock generator phase
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LOW   = 3'd1,
    PH_STALL = 3'd2,
    PH_WAIT  = 3'd3,
    PH_HIGH  = 3'd4
  } phase_e;

  // Control -> datapath strobes
  typedef struct packed {
    logic countRun;    // keep prescaler/tick counters running, else clear
    logic clrLowSeen;  // forget the "line seen low" flag
  } ctrl_strobe_t;

  // Datapath -> control status
  typedef struct packed {
    logic holdHit;   // hold delay reached in the current phase
    logic lowEnd;    // last cycle of the low phase count
    logic highEnd;   // last cycle of the high phase count
    logic lineHigh;  // synchronised SCL level
    logic lowSeen;   // synchronised SCL was low since last clear
  } dp_status_t;

endpackage

// File: rtl/scl_timing_dp.sv
`timescale 1ns/1ps
module scl_timing_dp import scl_timing_pkg::*; #(
  parameter int PRESC_W     = 4,
  parameter int PERIOD_W    = 8,
  parameter int DLY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic [PRESC_W+2*PERIOD_W+2*DLY_W-1:0] timingWord,
  input  logic sclIn,
  input  ctrl_strobe_t strobe,
  output dp_status_t status
);

  localparam int CNT_W = ((PERIOD_W > DLY_W + 1) ? PERIOD_W : DLY_W + 1) + 1;

  logic [PRESC_W-1:0]  cfgPresc;
  logic [PERIOD_W-1:0] cfgLow;
  logic [PERIOD_W-1:0] cfgHigh;
  logic [DLY_W-1:0]    cfgHold;
  logic [DLY_W-1:0]    cfgSetup;

  // Configuration follows the word while disabled, frozen while enabled (R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPresc <= '0;
      cfgLow   <= '0;
      cfgHigh  <= '0;
      cfgHold  <= '0;
      cfgSetup <= '0;
    end else if (!enable) begin
      {cfgPresc, cfgLow, cfgHigh, cfgHold, cfgSetup} <= timingWord;
    end
  end

  // Derived phase lengths in ticks
  logic [CNT_W-1:0] lowSpan;
  logic [CNT_W-1:0] dataSpan;
  logic [CNT_W-1:0] lowTicks;
  logic [CNT_W-1:0] highTicks;

  always_comb begin
    lowSpan   = CNT_W'(cfgLow) + CNT_W'(1);
    dataSpan  = CNT_W'(cfgHold) + CNT_W'(cfgSetup) + CNT_W'(1);
    lowTicks  = (dataSpan > lowSpan) ? dataSpan : lowSpan;
    highTicks = CNT_W'(cfgHigh) + CNT_W'(1);
  end

  // Shared prescaler and per-phase tick counter
  logic [PRESC_W-1:0] presCnt;
  logic [CNT_W-1:0]   tickCnt;
  logic               tickEdge;

  assign tickEdge = (presCnt == cfgPresc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0;
      tickCnt <= '0;
    end else if (!strobe.countRun) begin
      presCnt <= '0;
      tickCnt <= '0;
    end else if (tickEdge) begin
      presCnt <= '0;
      tickCnt <= tickCnt + CNT_W'(1);
    end else begin
      presCnt <= presCnt + PRESC_W'(1);
    end
  end

  // Line synchroniser
  logic [SYNC_STAGES-1:0] syncFf;
  logic                   lowSeenQ;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncFf <= '1;
        else       syncFf <= {syncFf[SYNC_STAGES-2:0], sclIn};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncFf <= '1;
        else       syncFf <= sclIn;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lowSeenQ <= 1'b0;
    else if (strobe.clrLowSeen) lowSeenQ <= 1'b0;
    else if (!syncFf[SYNC_STAGES-1]) lowSeenQ <= 1'b1;
  end

  always_comb begin
    status.holdHit  = (presCnt == '0) && (tickCnt == CNT_W'(cfgHold));
    status.lowEnd   = tickEdge && (tickCnt == lowTicks - CNT_W'(1));
    status.highEnd  = tickEdge && (tickCnt == highTicks - CNT_W'(1));
    status.lineHigh = syncFf[SYNC_STAGES-1];
    status.lowSeen  = lowSeenQ;
  end

  // R9: no capture while the previous cycle was enabled
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(enable) |-> $stable({cfgPresc, cfgLow, cfgHigh, cfgHold, cfgSetup}));

  // R2: prescaler never passes its terminal value
  assert_presc_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    presCnt <= cfgPresc);

endmodule

// File: rtl/scl_timing_ctrl.sv
`timescale 1ns/1ps
module scl_timing_ctrl import scl_timing_pkg::*; (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic runReq,
  input  logic stallReq,
  input  dp_status_t status,
  output ctrl_strobe_t strobe,
  output logic sclOut,
  output logic sdaShiftStb,
  output logic sclRiseStb
);

  phase_e phase;
  phase_e nextPhase;
  logic   driveLow;
  logic   counting;

  always_comb begin
    nextPhase = phase;
    if (!enable) begin
      nextPhase = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:  if (runReq) nextPhase = PH_LOW;
        PH_LOW:   if (status.lowEnd) nextPhase = stallReq ? PH_STALL : PH_WAIT;
        PH_STALL: if (!stallReq) nextPhase = PH_WAIT;
        PH_WAIT:  if (status.lineHigh && status.lowSeen) nextPhase = PH_HIGH;
        PH_HIGH:  if (status.highEnd) nextPhase = runReq ? PH_LOW : PH_IDLE;
        default:  nextPhase = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= nextPhase;
  end

  assign counting = (phase == PH_LOW) || (phase == PH_HIGH);
  assign driveLow = (phase == PH_LOW) || (phase == PH_STALL);

  always_comb begin
    strobe.countRun   = enable && counting && (nextPhase == phase);
    strobe.clrLowSeen = (nextPhase != phase) &&
                        ((nextPhase == PH_LOW) || (nextPhase == PH_HIGH));
    sclOut      = !(enable && driveLow);
    sdaShiftStb = enable && (phase == PH_LOW) && status.holdHit;
    sclRiseStb  = enable && !stallReq &&
                  (((phase == PH_LOW) && status.lowEnd) || (phase == PH_STALL));
  end

  // R5: a rise strobe is followed by a released line
  assert_rise_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    sclRiseStb |=> sclOut);

  // R8: one cycle after a disabled cycle the line is released
  assert_disable_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> sclOut);

  // R6: high count does not start while the synchronised line is low
  assert_stretch_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && phase == PH_WAIT && !status.lineHigh) |=> (phase == PH_WAIT));

  // R7: the stall phase is kept while requested
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && phase == PH_STALL && stallReq) |=> (phase == PH_STALL));

  // R4: the data strobe lasts a single cycle
  assert_sda_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    sdaShiftStb |=> !sdaShiftStb);

endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen import scl_timing_pkg::*; #(
  parameter int PRESC_W     = 4,
  parameter int PERIOD_W    = 8,
  parameter int DLY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic [PRESC_W+2*PERIOD_W+2*DLY_W-1:0] timingWord,
  input  logic runReq,
  input  logic stallReq,
  input  logic sclIn,
  output logic sclOut,
  output logic sdaShiftStb,
  output logic sclRiseStb
);

  ctrl_strobe_t strobe;
  dp_status_t   status;

  scl_timing_dp #(
    .PRESC_W    (PRESC_W),
    .PERIOD_W   (PERIOD_W),
    .DLY_W      (DLY_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .timingWord(timingWord),
    .sclIn     (sclIn),
    .strobe    (strobe),
    .status    (status)
  );

  scl_timing_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .runReq     (runReq),
    .stallReq   (stallReq),
    .status     (status),
    .strobe     (strobe),
    .sclOut     (sclOut),
    .sdaShiftStb(sdaShiftStb),
    .sclRiseStb (sclRiseStb)
  );

endmodule

// File: tb/scl_timing_gen_bench.sv
`timescale 1ns/1ps
module scl_timing_gen_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic runReq = 1'b0;
  logic stallReq = 1'b0;
  logic slaveHold = 1'b0;
  logic [27:0] timingWord = '0;
  logic sclIn;
  logic sclOut, sdaShiftStb, sclRiseStb;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign sclIn = sclOut & ~slaveHold;

  scl_timing_gen u_scl_timing_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .timingWord(timingWord),
    .runReq(runReq), .stallReq(stallReq), .sclIn(sclIn),
    .sclOut(sclOut), .sdaShiftStb(sdaShiftStb), .sclRiseStb(sclRiseStb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [27:0] mkWord(int p, int l, int h, int d, int s);
    return {p[3:0], l[7:0], h[7:0], d[3:0], s[3:0]};
  endfunction

  function automatic int lowCycles(int p, int l, int d, int s);
    int e;
    e = (d + s + 1 > l + 1) ? d + s + 1 : l + 1;
    return e * (p + 1);
  endfunction

  // ---------------- behavioural reference model ----------------
  int mPh = 0;           // 0 idle, 1 low, 2 stall, 3 wait, 4 high
  int mCyc = 0;
  bit mS1 = 1, mS2 = 1, mSaw = 0;
  int mP = 0, mL = 0, mH = 0, mD = 0, mSu = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mCyc = 0; mS1 = 1; mS2 = 1; mSaw = 0;
      mP = 0; mL = 0; mH = 0; mD = 0; mSu = 0;
    end else begin
      int nxt;
      nxt = mPh;
      if (!enable) begin
        mP = timingWord[27:24]; mL = timingWord[23:16]; mH = timingWord[15:8];
        mD = timingWord[7:4];   mSu = timingWord[3:0];
        nxt = 0;
      end else begin
        case (mPh)
          0: if (runReq) nxt = 1;
          1: if (mCyc == lowCycles(mP, mL, mD, mSu) - 1) nxt = stallReq ? 2 : 3;
          2: if (!stallReq) nxt = 3;
          3: if (mS2 && mSaw) nxt = 4;
          4: if (mCyc == (mH + 1) * (mP + 1) - 1) nxt = runReq ? 1 : 0;
          default: nxt = 0;
        endcase
      end
      if (nxt != mPh && (nxt == 1 || nxt == 4)) mSaw = 0;
      else if (!mS2) mSaw = 1;
      mCyc = (nxt == mPh) ? mCyc + 1 : 0;
      mPh = nxt;
      mS2 = mS1;
      mS1 = sclIn;
    end
  end

  // per-cycle comparison, away from the active edge
  always begin
    @(negedge clk);
    #1;
    if (rstN && !finished) begin
      bit eScl, eSda, eRise;
      eScl  = !(enable && (mPh == 1 || mPh == 2));
      eSda  = enable && mPh == 1 && mCyc == mD * (mP + 1);
      eRise = enable && !stallReq &&
              ((mPh == 1 && mCyc == lowCycles(mP, mL, mD, mSu) - 1) || mPh == 2);
      chk(sclOut == eScl, "R2 sclOut per-cycle", int'(sclOut), int'(eScl));
      chk(sdaShiftStb == eSda, "R4 sdaShiftStb per-cycle", int'(sdaShiftStb), int'(eSda));
      chk(sclRiseStb == eRise, "R5 sclRiseStb per-cycle", int'(sclRiseStb), int'(eRise));
    end
  end

  // ---------------- stretching slave ----------------
  int stretchLen = 0;
  int stretchLeft = 0;
  bit prevScl = 1;

  always @(negedge clk) begin
    if (stretchLeft > 0) begin
      stretchLeft--;
      if (stretchLeft == 0) slaveHold = 1'b0;
    end else if (!prevScl && sclOut && stretchLen > 0) begin
      slaveHold = 1'b1;
      stretchLeft = stretchLen;
    end
    prevScl = sclOut;
  end

  // ---------------- helpers ----------------
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic waitFall();
    while (sclOut == 1'b0) step();
    while (sclOut == 1'b1) step();
  endtask

  task automatic measureLow(output int n, output int sdaIdx, output bit lastRise);
    n = 0; sdaIdx = -1; lastRise = 0;
    while (sclOut == 1'b0) begin
      if (sdaShiftStb) sdaIdx = n;
      lastRise = sclRiseStb;
      n++;
      step();
    end
  endtask

  task automatic measureHigh(output int n);
    n = 0;
    while (sclOut == 1'b1) begin
      n++;
      step();
    end
  endtask

  task automatic loadCfg(input logic [27:0] w);
    @(negedge clk) enable = 1'b0; timingWord = w;
    @(negedge clk);
    @(negedge clk) enable = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired, stimulus did not complete", 0, 1);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- directed stimulus ----------------
  initial begin
    int n, sIdx, hiN;
    bit lr;
    logic [27:0] cfgA, cfgB, cfgC;
    cfgA = mkWord(1, 4, 3, 2, 1);  // low 10, high 3+8, sda at 4
    cfgB = mkWord(0, 1, 0, 5, 6);  // low 12 (delays dominate), high 3+1, sda at 5
    cfgC = mkWord(2, 2, 1, 0, 0);  // low 9, high 3+6, sda at 0

    // R1: reset state
    repeat (3) step();
    chk(sclOut == 1'b1, "R1 sclOut in reset", int'(sclOut), 1);
    chk(!sdaShiftStb && !sclRiseStb, "R1 strobes in reset", int'(sdaShiftStb | sclRiseStb), 0);
    @(negedge clk) rstN = 1'b1;
    repeat (2) step();
    chk(sclOut == 1'b1, "R1 sclOut after reset", int'(sclOut), 1);

    // R2, R3, R5: basic period with config A
    loadCfg(cfgA);
    @(negedge clk) runReq = 1'b1;
    waitFall();
    measureLow(n, sIdx, lr);
    chk(n == 10, "R2 low length cfgA", n, 10);
    chk(sIdx == 4, "R4 sda offset cfgA", sIdx, 4);
    chk(lr == 1'b1, "R5 rise strobe on last low cycle", int'(lr), 1);
    chk((n - sIdx) >= 2 * (1 + 1), "R5 setup span before release", n - sIdx, 4);
    measureHigh(hiN);
    chk(hiN == 11, "R3 released length cfgA", hiN, 11);

    // R9: word change while enabled is ignored
    @(negedge clk) timingWord = cfgB;
    waitFall();
    measureLow(n, sIdx, lr);
    chk(n == 10, "R9 low length unchanged while enabled", n, 10);

    // R6: slave stretches 7 cycles
    stretchLen = 7;
    waitFall();
    measureLow(n, sIdx, lr);
    measureHigh(hiN);
    chk(hiN == 18, "R6 released length with stretch", hiN, 18);
    stretchLen = 0;

    // R7: stall request holds SCL low
    while (sclOut == 1'b0) step();
    @(negedge clk) stallReq = 1'b1;
    waitFall();
    n = 0;
    repeat (24) begin
      step();
      if (sclOut == 1'b0) n++;
    end
    chk(n == 24, "R7 low held during stall", n, 24);
    @(negedge clk) stallReq = 1'b0;
    #1;
    chk(sclRiseStb == 1'b1 && sclOut == 1'b0, "R7 rise strobe when stall drops",
        int'(sclRiseStb), 1);
    step();
    chk(sclOut == 1'b1, "R7 release after stall", int'(sclOut), 1);

    // R8: disable in the middle of a low phase, then new config applies (R9)
    waitFall();
    repeat (2) step();
    @(negedge clk) begin enable = 1'b0; timingWord = cfgC; end
    #1;
    chk(sclOut == 1'b1, "R8 release on disable", int'(sclOut), 1);
    chk(!sdaShiftStb && !sclRiseStb, "R8 strobes quiet when disabled",
        int'(sdaShiftStb | sclRiseStb), 0);
    repeat (4) step();
    @(negedge clk) enable = 1'b1;
    waitFall();
    chk(sdaShiftStb == 1'b1, "R4 zero hold strobes on first low cycle", int'(sdaShiftStb), 1);
    measureLow(n, sIdx, lr);
    chk(n == 9, "R9 new config after re-enable, R8 fresh counters", n, 9);
    measureHigh(hiN);
    chk(hiN == 9, "R3 released length cfgC", hiN, 9);

    // R2, R4: delays dominate the low time
    loadCfg(cfgB);
    waitFall();
    measureLow(n, sIdx, lr);
    chk(n == 12, "R2 low length set by hold plus setup", n, 12);
    chk(sIdx == 5, "R4 sda offset cfgB", sIdx, 5);
    measureHigh(hiN);
    chk(hiN == 4, "R3 released length cfgB", hiN, 4);

    // R10: stop and restart
    @(negedge clk) runReq = 1'b0;
    repeat (40) step();
    n = 0;
    repeat (30) begin
      step();
      if (sclOut == 1'b1) n++;
    end
    chk(n == 30, "R10 idle keeps SCL released", n, 30);
    @(negedge clk) runReq = 1'b1;
    step();
    chk(sclOut == 1'b0, "R10 falls one cycle after run request", int'(sclOut), 0);
    repeat (20) step();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule